// File: doc/BRIEF.md
# Branch Decision and Target Unit

This block decides, for one control-transfer instruction at a time, whether the transfer happens. It also works out where execution continues and whether a return address has to be written into link register R6. The caller presents the condition flags, a 4-bit condition code, the kind of transfer and its operands together with a request strobe. One clock later the block answers with a taken bit, the next instruction address, a link write enable with its value, and an error strobe for encodings that are not allowed.

There are three kinds of transfer. A short relative branch carries a signed 8-bit distance counted in 16-bit words. A long absolute jump carries a full 16-bit destination in its second instruction word, so the instruction is 4 bytes long. A register-indirect branch jumps to a register value and can optionally link. On the absolute jump, the top condition code turns the jump into an unconditional jump with link. A return is simply an indirect branch through R6.

Top module: `bru_unit`

## Requirements
- R1: While reset is asserted, and at the first sampling point after it, every output is zero.
- R2: All outputs are registered with one clock of latency. A cycle with `req_valid` low gives zero on `out_valid`, `out_taken`, `out_link_we`, `out_bad`, `out_next_pc` and `out_link_val` in the next cycle.
- R3: The flags are packed as `flags[3]`=N, `flags[2]`=Z, `flags[1]`=C, `flags[0]`=V. These codes hold as follows: 0 when Z, 1 when not Z, 6 when C, 7 when not C, 8 when V, 9 when not V, 10 always, 13 when N, 14 when not N.
- R4: The signed codes hold as follows: 2 (less) when N differs from V, 3 (greater-or-equal) when N equals V, 4 (greater) when Z is clear and N equals V, 5 (less-or-equal) when Z is set or N differs from V.
- R5: The unsigned codes hold as follows: 11 (higher) when C and Z are both clear, 12 (lower-or-same) when C or Z is set.
- R6: `kind` encoding is 0 relative, 1 absolute, 2 indirect, 3 reserved. A relative branch whose code holds goes to `pc` plus the sign-extended offset times two, modulo 2^16. A relative branch whose code fails goes to `pc`+2.
- R7: A relative branch with code 15 is not taken, raises `out_bad`, goes to `pc`+2 and does not link.
- R8: An absolute jump with codes 0 to 14 goes to `abs_addr` when its code holds and to `pc`+4 when it fails, and never links.
- R9: An absolute jump with code 15 is always taken to `abs_addr`, asserts `out_link_we`, and gives `out_link_val` = `pc`+4.
- R10: An indirect branch is always taken to `ind_addr`, ignoring flags and code. It asserts `out_link_we` exactly when `link_req` is 1, and then `out_link_val` = `pc`+2.
- R11: Reserved kind 3 is not taken, raises `out_bad`, goes to `pc`+2 and does not link.
- R12: Whenever `out_link_we` is 0, `out_link_val` is 0. `out_link_we` and `out_bad` never stand with the wrong `out_taken` value: link needs taken, and bad needs not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A transfer is presented this cycle |
| kind | input | 2 | 0 relative, 1 absolute, 2 indirect, 3 reserved |
| cond | input | 4 | Condition code |
| flags | input | 4 | N, Z, C, V from bit 3 down to bit 0 |
| rel_off | input | 8 | Signed word distance for relative branches |
| abs_addr | input | 16 | Destination of an absolute jump |
| ind_addr | input | 16 | Register value for an indirect branch |
| link_req | input | 1 | Indirect branch wants a link |
| pc | input | 16 | Address of the transfer instruction |
| out_valid | output | 1 | Registered copy of the request strobe |
| out_taken | output | 1 | The transfer happens |
| out_next_pc | output | 16 | Address of the next instruction to execute |
| out_link_we | output | 1 | Write `out_link_val` into R6 |
| out_link_val | output | 16 | Return address, zero when not linking |
| out_bad | output | 1 | Disallowed encoding seen |

## Verification
The hardest cases to reach are the ones where a condition code meets a flag pattern that flips its outcome. Examples are greater-than with Z set while N equals V, or higher with only C set. Others are the wrap of a backward branch near address zero and a forward branch near the top of memory. The stimulus therefore sweeps every condition code against all sixteen flag patterns for both the relative and the absolute kind, using extreme offsets and program counters next to the wrap points. It then runs a long stretch of random requests, with idle cycles mixed in, so that back-to-back results and return to quiet are covered as well.

// File: rtl/bru_pkg.sv
package bru_pkg;

  typedef enum logic [1:0] {
    KIND_REL = 2'd0,
    KIND_ABS = 2'd1,
    KIND_IND = 2'd2,
    KIND_RSV = 2'd3
  } bru_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } bru_flags_t;

  localparam int CC_W = 4;

  localparam logic [CC_W-1:0] CC_EQ  = 4'd0;
  localparam logic [CC_W-1:0] CC_NE  = 4'd1;
  localparam logic [CC_W-1:0] CC_LT  = 4'd2;
  localparam logic [CC_W-1:0] CC_GE  = 4'd3;
  localparam logic [CC_W-1:0] CC_GT  = 4'd4;
  localparam logic [CC_W-1:0] CC_LE  = 4'd5;
  localparam logic [CC_W-1:0] CC_CS  = 4'd6;
  localparam logic [CC_W-1:0] CC_CC  = 4'd7;
  localparam logic [CC_W-1:0] CC_VS  = 4'd8;
  localparam logic [CC_W-1:0] CC_VC  = 4'd9;
  localparam logic [CC_W-1:0] CC_AL  = 4'd10;
  localparam logic [CC_W-1:0] CC_HI  = 4'd11;
  localparam logic [CC_W-1:0] CC_LS  = 4'd12;
  localparam logic [CC_W-1:0] CC_MI  = 4'd13;
  localparam logic [CC_W-1:0] CC_PL  = 4'd14;
  localparam logic [CC_W-1:0] CC_LNK = 4'd15;

  // Truth of a condition code for a flag set. The link code reads as true,
  // the caller decides whether that code is allowed for the kind at hand.
  function automatic logic cc_holds(input logic [CC_W-1:0] cc, input bru_flags_t f);
    logic sgn_lt;
    sgn_lt = f.n ^ f.v;
    unique case (cc)
      CC_EQ:   cc_holds = f.z;
      CC_NE:   cc_holds = ~f.z;
      CC_LT:   cc_holds = sgn_lt;
      CC_GE:   cc_holds = ~sgn_lt;
      CC_GT:   cc_holds = ~f.z & ~sgn_lt;
      CC_LE:   cc_holds = f.z | sgn_lt;
      CC_CS:   cc_holds = f.c;
      CC_CC:   cc_holds = ~f.c;
      CC_VS:   cc_holds = f.v;
      CC_VC:   cc_holds = ~f.v;
      CC_AL:   cc_holds = 1'b1;
      CC_HI:   cc_holds = ~f.c & ~f.z;
      CC_LS:   cc_holds = f.c | f.z;
      CC_MI:   cc_holds = f.n;
      CC_PL:   cc_holds = ~f.n;
      default: cc_holds = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/bru_cond.sv
module bru_cond
  import bru_pkg::*;
(
  input  bru_kind_e        kind,
  input  logic [CC_W-1:0]  cond,
  input  bru_flags_t       flags,
  input  logic             link_req,
  output logic             take,
  output logic             want_link,
  output logic             illegal
);

  logic cc_true;
  logic is_lnk_code;

  assign cc_true     = cc_holds(cond, flags);
  assign is_lnk_code = (cond == CC_LNK);

  always_comb begin
    take      = 1'b0;
    want_link = 1'b0;
    illegal   = 1'b0;
    unique case (kind)
      KIND_REL: begin
        illegal = is_lnk_code;
        take    = cc_true & ~is_lnk_code;
      end
      KIND_ABS: begin
        take      = cc_true;
        want_link = is_lnk_code;
      end
      KIND_IND: begin
        take      = 1'b1;
        want_link = link_req;
      end
      default: begin
        illegal = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/bru_target.sv
module bru_target
  import bru_pkg::*;
#(
  parameter int AW = 16,
  parameter int OW = 8
) (
  input  bru_kind_e        kind,
  input  logic             take,
  input  logic [AW-1:0]    pc,
  input  logic [OW-1:0]    rel_off,
  input  logic [AW-1:0]    abs_addr,
  input  logic [AW-1:0]    ind_addr,
  output logic [AW-1:0]    next_pc,
  output logic [AW-1:0]    seq_pc
);

  localparam int SHORT_BYTES = 2;
  localparam int LONG_BYTES  = 4;

  // Word distance turned into a byte address, wrapping at the top.
  function automatic logic [AW-1:0] rel_dest(input logic [AW-1:0] base,
                                             input logic [OW-1:0] off);
    logic [AW-1:0] ext;
    ext = AW'($signed(off));
    return base + (ext << 1);
  endfunction

  function automatic logic [AW-1:0] step_over(input logic [AW-1:0] base, input logic is_long);
    return base + (is_long ? AW'(LONG_BYTES) : AW'(SHORT_BYTES));
  endfunction

  assign seq_pc = step_over(pc, kind == KIND_ABS);

  always_comb begin
    next_pc = seq_pc;
    if (take) begin
      unique case (kind)
        KIND_REL: next_pc = rel_dest(pc, rel_off);
        KIND_ABS: next_pc = abs_addr;
        KIND_IND: next_pc = ind_addr;
        default:  next_pc = seq_pc;
      endcase
    end
  end

endmodule

// File: rtl/bru_unit.sv
module bru_unit
  import bru_pkg::*;
#(
  parameter int AW = 16,
  parameter int OW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [1:0]      kind,
  input  logic [3:0]      cond,
  input  logic [3:0]      flags,
  input  logic [OW-1:0]   rel_off,
  input  logic [AW-1:0]   abs_addr,
  input  logic [AW-1:0]   ind_addr,
  input  logic            link_req,
  input  logic [AW-1:0]   pc,
  output logic            out_valid,
  output logic            out_taken,
  output logic [AW-1:0]   out_next_pc,
  output logic            out_link_we,
  output logic [AW-1:0]   out_link_val,
  output logic            out_bad
);

  bru_kind_e  kind_e;
  bru_flags_t flags_s;

  assign kind_e  = bru_kind_e'(kind);
  assign flags_s = bru_flags_t'(flags);

  // Named internal events, visible to the assertions below.
  logic          ev_take;
  logic          ev_link;
  logic          ev_illegal;
  logic [AW-1:0] ev_dest;
  logic [AW-1:0] ev_seq;

  bru_cond u_cond (
    .kind      (kind_e),
    .cond      (cond),
    .flags     (flags_s),
    .link_req  (link_req),
    .take      (ev_take),
    .want_link (ev_link),
    .illegal   (ev_illegal)
  );

  bru_target #(.AW(AW), .OW(OW)) u_target (
    .kind     (kind_e),
    .take     (ev_take),
    .pc       (pc),
    .rel_off  (rel_off),
    .abs_addr (abs_addr),
    .ind_addr (ind_addr),
    .next_pc  (ev_dest),
    .seq_pc   (ev_seq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !req_valid) begin
      out_valid    <= 1'b0;
      out_taken    <= 1'b0;
      out_next_pc  <= '0;
      out_link_we  <= 1'b0;
      out_link_val <= '0;
      out_bad      <= 1'b0;
    end else begin
      out_valid    <= 1'b1;
      out_taken    <= ev_take;
      out_next_pc  <= ev_dest;
      out_link_we  <= ev_link;
      out_link_val <= ev_link ? ev_seq : '0;
      out_bad      <= ev_illegal;
    end
  end

  p_link_needs_take_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_link_we |-> out_taken);

  p_bad_not_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_bad |-> !out_taken);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!out_valid && !out_taken && !out_link_we && !out_bad &&
                    out_next_pc == '0 && out_link_val == '0));

  p_ind_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && kind == 2'd2) |=> (out_taken && out_next_pc == $past(ind_addr)));

  p_always_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !kind[1] && cond == 4'd10) |=> out_taken);

  p_abs_link_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && kind == 2'd1 && cond == 4'd15) |=>
      (out_link_we && out_link_val == AW'($past(pc) + AW'(4))));

  p_rsv_bad_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && kind == 2'd3) |=> (out_bad && !out_link_we));

endmodule

// File: tb/tb_bru_unit.sv
`timescale 1ns/1ps
module tb_bru_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  kind = '0;
  logic [3:0]  cond = '0;
  logic [3:0]  flags = '0;
  logic [7:0]  rel_off = '0;
  logic [15:0] abs_addr = '0;
  logic [15:0] ind_addr = '0;
  logic        link_req = 1'b0;
  logic [15:0] pc = '0;
  logic        out_valid, out_taken, out_link_we, out_bad;
  logic [15:0] out_next_pc, out_link_val;

  always #2 clk = ~clk;

  bru_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .kind(kind), .cond(cond),
    .flags(flags), .rel_off(rel_off), .abs_addr(abs_addr), .ind_addr(ind_addr),
    .link_req(link_req), .pc(pc), .out_valid(out_valid), .out_taken(out_taken),
    .out_next_pc(out_next_pc), .out_link_we(out_link_we),
    .out_link_val(out_link_val), .out_bad(out_bad)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // expected outputs for the request applied at the previous falling edge
  logic        e_valid, e_taken, e_lw, e_bad;
  logic [15:0] e_next, e_lv;
  string       e_tag;

  task automatic model(input logic v, input logic [1:0] k, input logic [3:0] cc,
                       input logic [3:0] f, input logic [7:0] off, input logic [15:0] ab,
                       input logic [15:0] ind, input logic lk, input logic [15:0] p);
    bit n, z, c, vv, hold;
    string ctag;
    int so, seq;
    n = f[3]; z = f[2]; c = f[1]; vv = f[0];
    e_valid = v; e_taken = 0; e_lw = 0; e_bad = 0; e_next = 0; e_lv = 0;
    if (!v) begin
      e_tag = "R2";
      return;
    end
    case (int'(cc))
      0: hold = z;            1: hold = !z;
      2: hold = (n != vv);    3: hold = (n == vv);
      4: hold = !z && (n == vv);
      5: hold = z || (n != vv);
      6: hold = c;            7: hold = !c;
      8: hold = vv;           9: hold = !vv;
      11: hold = !(c || z);   12: hold = c || z;
      13: hold = n;           14: hold = !n;
      default: hold = 1;
    endcase
    if (cc >= 2 && cc <= 5) ctag = "R4";
    else if (cc == 11 || cc == 12) ctag = "R5";
    else ctag = "R3";
    seq = (int'(p) + ((k == 2'd1) ? 4 : 2)) & 'hFFFF;
    so = int'($signed(off));
    case (k)
      2'd0: begin
        if (cc == 4'd15) begin
          e_bad = 1; e_next = 16'(seq); e_tag = "R7";
        end else begin
          e_taken = hold;
          e_next = hold ? 16'((int'(p) + 2 * so) & 'hFFFF) : 16'(seq);
          e_tag = {ctag, " R6"};
        end
      end
      2'd1: begin
        if (cc == 4'd15) begin
          e_taken = 1; e_lw = 1; e_lv = 16'(seq); e_next = ab; e_tag = "R9";
        end else begin
          e_taken = hold; e_next = hold ? ab : 16'(seq); e_tag = {ctag, " R8"};
        end
      end
      2'd2: begin
        e_taken = 1; e_next = ind; e_lw = lk; e_lv = lk ? 16'(seq) : 16'd0; e_tag = "R10";
      end
      default: begin
        e_bad = 1; e_next = 16'(seq); e_tag = "R11";
      end
    endcase
    if (!e_lw) e_tag = {e_tag, " R12"};
  endtask

  task automatic check_now();
    total++;
    if (out_valid !== e_valid || out_taken !== e_taken || out_link_we !== e_lw ||
        out_bad !== e_bad || out_next_pc !== e_next || out_link_val !== e_lv) begin
      bad++;
      $display("FAIL %s: got v=%b t=%b nx=%h lw=%b lv=%h b=%b exp v=%b t=%b nx=%h lw=%b lv=%h b=%b",
               e_tag, out_valid, out_taken, out_next_pc, out_link_we, out_link_val, out_bad,
               e_valid, e_taken, e_next, e_lw, e_lv, e_bad);
    end
  endtask

  // one step: check the previous request, then present a new one
  task automatic step(input logic v, input logic [1:0] k, input logic [3:0] cc,
                      input logic [3:0] f, input logic [7:0] off, input logic [15:0] ab,
                      input logic [15:0] ind, input logic lk, input logic [15:0] p);
    @(negedge clk);
    check_now();
    req_valid = v; kind = k; cond = cc; flags = f; rel_off = off;
    abs_addr = ab; ind_addr = ind; link_req = lk; pc = p;
    model(v, k, cc, f, off, ab, ind, lk, p);
  endtask

  initial begin
    #(4.0 * 150000);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog: got hung exp done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    e_valid = 0; e_taken = 0; e_lw = 0; e_bad = 0; e_next = 0; e_lv = 0;
    // R1: outputs during and right after reset
    e_tag = "R1";
    repeat (3) @(negedge clk);
    check_now();
    rst_n = 1'b1;
    // R3 R4 R5 R6 R7: relative kind, every code against every flag pattern
    for (int cc = 0; cc < 16; cc++)
      for (int f = 0; f < 16; f++)
        step(1, 2'd0, 4'(cc), 4'(f), (f[0] ? 8'h80 : 8'h7F), 16'h1234, 16'h0,
             0, (f[1] ? 16'h0004 : 16'hFFF0));
    // R8 R9: absolute kind, every code against every flag pattern
    for (int cc = 0; cc < 16; cc++)
      for (int f = 0; f < 16; f++)
        step(1, 2'd1, 4'(cc), 4'(f), 8'h00, 16'(16'hA000 + cc * 16 + f), 16'h0,
             0, (f[2] ? 16'hFFFC : 16'h0200));
    // R10: indirect with and without link, including a return through R6
    step(1, 2'd2, 4'd0, 4'h0, 8'h00, 16'h0, 16'h5556, 1'b0, 16'h0100);
    step(1, 2'd2, 4'd7, 4'hF, 8'h00, 16'h0, 16'hBEEE, 1'b1, 16'hFFFE);
    step(1, 2'd2, 4'd15, 4'h4, 8'h00, 16'h0, 16'h0042, 1'b1, 16'h3000);
    // R11: reserved kind
    step(1, 2'd3, 4'd10, 4'h0, 8'h10, 16'h7777, 16'h8888, 1'b1, 16'h0400);
    step(1, 2'd3, 4'd15, 4'hF, 8'h10, 16'h7777, 16'h8888, 1'b0, 16'hFFFE);
    // R2: idle in between and back to back
    step(0, 2'd1, 4'd15, 4'h0, 8'h00, 16'h1111, 16'h0, 1'b1, 16'h0800);
    step(1, 2'd1, 4'd15, 4'h0, 8'h00, 16'h1111, 16'h0, 1'b0, 16'h0800);
    step(0, 2'd2, 4'd0, 4'h0, 8'h00, 16'h0, 16'h2222, 1'b1, 16'h0900);
    // mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r, s;
      r = $urandom; s = $urandom;
      step(r[31:29] != 3'd0, r[1:0], r[5:2], r[9:6], r[17:10], s[15:0], s[31:16],
           r[18], {r[28:19], s[5:0]});
    end
    step(0, 2'd0, 4'd0, 4'h0, 8'h0, 16'h0, 16'h0, 1'b0, 16'h0);
    @(negedge clk);
    check_now();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule